// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, every cycle, which of eight hardware threads may fetch instructions in a simultaneous multithreading front end, and how many fetch slots each chosen thread receives. It keeps three saturating counters per thread. The first counts unissued instructions: it grows with fetched instructions, and shrinks with issued and squashed ones. The second counts unresolved branches. The third counts outstanding data-cache misses.

A policy input picks plain rotation or one of the three counters as the priority key. In the counter policies, the eligible thread with the smallest key wins. A split input asks for one thread per cycle or for two threads per cycle. Threads that cannot fetch, for example one waiting on an instruction-cache refill, are removed through a per-thread eligibility mask.

Grants are registered. They reflect the counters, the mask and the mode sampled at the previous clock edge. In the counter policies with two threads, the second thread receives the slots the first one left unused. The first thread reports how many it used on a count input in the cycle its grant is visible.

Top module: `fetch_thread_sel`

## Requirements
- R1: After reset, both grant valid outputs are low, the second slot output is 0, all counters are zero and the rotation pointer is at thread 0.
- R2: The unissued-instruction counter of thread t changes in one edge by fetched[t] minus issued[t] minus squashed[t], all applied together.
- R3: Every counter clamps at 2^CW-1 (63 by default) instead of wrapping, and at 0 instead of going negative.
- R4: The branch counter of thread t rises by one on br_new[t] and falls by one on br_done[t]; the miss counter does the same with miss_new[t] and miss_done[t].
- R5: With policy 0 (rotation) and split low, one eligible thread per cycle is granted in rotating order with a budget of 8 slots.
- R6: With policy 0 and split high, two distinct eligible threads are granted in rotating order, each with 4 slots.
- R7: Policies 1, 2 and 3 grant the eligible thread with the smallest unissued, branch or miss count respectively; with split high the second grant goes to the smallest among the rest.
- R8: Equal keys are resolved in rotation order starting at the pointer; after any grant the pointer moves to the thread following the last thread granted (second if valid, else first).
- R9: A thread whose eligibility bit was low at the sampling edge is never granted; with no eligible thread both valid outputs are low.
- R10: In a split mode with a single eligible thread, only the first grant is valid; the second valid is low and its slot output is 0.
- R11: In a counter policy with split high, the first thread gets 8 slots and the second gets 8 minus used0 (0 when used0 is 8 or more), combinationally from used0.
- R12: Grant outputs change only at a clock edge and reflect the inputs and counters from before that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pol_i | input | 2 | Policy: 0 rotation, 1 unissued count, 2 branch count, 3 miss count |
| dual_i | input | 1 | High: two threads per cycle |
| elig_i | input | NTHR | Per-thread fetch eligibility |
| fetched_i | input | NTHR*SW | Instructions fetched per thread, SW bits each, thread t at bits t*SW |
| issued_i | input | NTHR*SW | Instructions issued per thread |
| squashed_i | input | NTHR*CW | Instructions squashed per thread on a flush |
| br_new_i | input | NTHR | A new branch entered the window, per thread |
| br_done_i | input | NTHR | A branch resolved, per thread |
| miss_new_i | input | NTHR | A data-cache miss started, per thread |
| miss_done_i | input | NTHR | A data-cache miss returned, per thread |
| used0_i | input | SW | Slots used by the currently visible first grant |
| g0_vld_o | output | 1 | First grant valid |
| g0_tid_o | output | TW | First granted thread |
| g0_slots_o | output | SW | Slot budget of the first grant |
| g1_vld_o | output | 1 | Second grant valid |
| g1_tid_o | output | TW | Second granted thread |
| g1_slots_o | output | SW | Slot budget of the second grant |

## Verification
Selection is driven with all-equal counters, so only the rotation pointer decides and wrap-around becomes visible. It is also driven with all-distinct counters, so only the minimum search decides and the pointer must not matter. Sparse eligibility masks separate skipping of blocked threads from plain counting. Masks with a single eligible thread isolate the missing second grant. Counter loads built from overflowing fetch bursts, oversized squashes and fetch/issue in one edge tell clamping apart from wrapping. Pairs of threads are set up so that the unissued, branch and miss policies each pick a different winner.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE   = 2'd0,
    POL_INFLIGHT = 2'd1,
    POL_BRANCH   = 2'd2,
    POL_MISS     = 2'd3
  } policy_e;

  // successor index in a ring of n entries
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/fts_rst_sync.sv
module fts_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/fts_sat_ctr.sv
module fts_sat_ctr #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] inc_i,
  input  logic [CW-1:0] dec_a_i,
  input  logic [CW-1:0] dec_b_i,
  output logic [CW-1:0] cnt_o
);
  localparam int XW   = CW + 2;
  localparam int MAXV = (1 << CW) - 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic [XW-1:0] up, down, rem;
  logic          en;

  always_comb begin
    up   = XW'(cnt_q) + XW'(inc_i);
    down = XW'(dec_a_i) + XW'(dec_b_i);
    rem  = up - down;
    en   = (|inc_i) | (|dec_a_i) | (|dec_b_i);
    if (down >= up)             cnt_n = '0;
    else if (rem > XW'(MAXV))   cnt_n = CW'(MAXV);
    else                        cnt_n = rem[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int N  = 8,
  parameter int KW = 6,
  parameter int TW = 3
) (
  input  logic [N*KW-1:0] keys_i,
  input  logic [N-1:0]    cand_i,
  input  logic [TW-1:0]   start_i,
  output logic            vld_o,
  output logic [TW-1:0]   tid_o
);
  logic [KW-1:0] best;
  int            idx;

  // walk the ring from the pointer; strict less-than keeps the earliest tie
  always_comb begin
    vld_o = 1'b0;
    tid_o = '0;
    best  = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(start_i) + k) % N;
      if (cand_i[idx] && (!vld_o || (keys_i[idx*KW +: KW] < best))) begin
        vld_o = 1'b1;
        tid_o = TW'(idx);
        best  = keys_i[idx*KW +: KW];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR  = 8,
  parameter int CW    = 6,
  parameter int SLOTS = 8,
  localparam int TW   = $clog2(NTHR),
  localparam int SW   = $clog2(SLOTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         pol_i,
  input  logic               dual_i,
  input  logic [NTHR-1:0]    elig_i,
  input  logic [NTHR*SW-1:0] fetched_i,
  input  logic [NTHR*SW-1:0] issued_i,
  input  logic [NTHR*CW-1:0] squashed_i,
  input  logic [NTHR-1:0]    br_new_i,
  input  logic [NTHR-1:0]    br_done_i,
  input  logic [NTHR-1:0]    miss_new_i,
  input  logic [NTHR-1:0]    miss_done_i,
  input  logic [SW-1:0]      used0_i,
  output logic               g0_vld_o,
  output logic [TW-1:0]      g0_tid_o,
  output logic [SW-1:0]      g0_slots_o,
  output logic               g1_vld_o,
  output logic [TW-1:0]      g1_tid_o,
  output logic [SW-1:0]      g1_slots_o
);
  import fts_pkg::*;

  localparam int HALF = SLOTS / 2;

  logic             rst_n_s;
  policy_e          pol;
  logic [NTHR*CW-1:0] keys;
  logic [CW-1:0]    cnt_inf [NTHR];
  logic [CW-1:0]    cnt_br  [NTHR];
  logic [CW-1:0]    cnt_ms  [NTHR];

  logic             p0_vld, p1_vld;
  logic [TW-1:0]    p0_tid, p1_tid;
  logic [NTHR-1:0]  rest;

  logic             g0_vld_q, g0_vld_n, g1_vld_q, g1_vld_n;
  logic [TW-1:0]    g0_tid_q, g0_tid_n, g1_tid_q, g1_tid_n;
  logic [SW-1:0]    g0_slot_q, g0_slot_n;
  logic             g1_fill_q, g1_fill_n;
  logic [TW-1:0]    ptr_q, ptr_n;
  logic             ptr_en;
  logic [SW-1:0]    left;

  assign pol = policy_e'(pol_i);

  fts_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  // per-thread bookkeeping and priority key selection
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    fts_sat_ctr #(.CW(CW)) u_inf (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_s),
      .inc_i   (CW'(fetched_i[t*SW +: SW])),
      .dec_a_i (CW'(issued_i[t*SW +: SW])),
      .dec_b_i (squashed_i[t*CW +: CW]),
      .cnt_o   (cnt_inf[t])
    );
    fts_sat_ctr #(.CW(CW)) u_br (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_s),
      .inc_i   (CW'(br_new_i[t])),
      .dec_a_i (CW'(br_done_i[t])),
      .dec_b_i ('0),
      .cnt_o   (cnt_br[t])
    );
    fts_sat_ctr #(.CW(CW)) u_ms (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_s),
      .inc_i   (CW'(miss_new_i[t])),
      .dec_a_i (CW'(miss_done_i[t])),
      .dec_b_i ('0),
      .cnt_o   (cnt_ms[t])
    );

    always_comb begin
      unique case (pol)
        POL_INFLIGHT: keys[t*CW +: CW] = cnt_inf[t];
        POL_BRANCH:   keys[t*CW +: CW] = cnt_br[t];
        POL_MISS:     keys[t*CW +: CW] = cnt_ms[t];
        default:      keys[t*CW +: CW] = '0;
      endcase
    end
  end

  fts_pick #(.N(NTHR), .KW(CW), .TW(TW)) u_pick0 (
    .keys_i  (keys),
    .cand_i  (elig_i),
    .start_i (ptr_q),
    .vld_o   (p0_vld),
    .tid_o   (p0_tid)
  );

  always_comb begin
    rest = elig_i;
    if (p0_vld) rest[p0_tid] = 1'b0;
  end

  fts_pick #(.N(NTHR), .KW(CW), .TW(TW)) u_pick1 (
    .keys_i  (keys),
    .cand_i  (rest),
    .start_i (ptr_q),
    .vld_o   (p1_vld),
    .tid_o   (p1_tid)
  );

  // next grant and pointer
  always_comb begin
    g0_vld_n  = p0_vld;
    g0_tid_n  = p0_tid;
    g1_vld_n  = dual_i && p1_vld;
    g1_tid_n  = p1_tid;
    g1_fill_n = (pol != POL_ROTATE);
    if (!p0_vld)                          g0_slot_n = '0;
    else if (dual_i && pol == POL_ROTATE) g0_slot_n = SW'(HALF);
    else                                  g0_slot_n = SW'(SLOTS);
    ptr_en = p0_vld;
    if (g1_vld_n) ptr_n = TW'(ring_next(int'(p1_tid), NTHR));
    else          ptr_n = TW'(ring_next(int'(p0_tid), NTHR));
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      g0_vld_q  <= 1'b0;
      g0_tid_q  <= '0;
      g0_slot_q <= '0;
      g1_vld_q  <= 1'b0;
      g1_tid_q  <= '0;
      g1_fill_q <= 1'b0;
    end else begin
      g0_vld_q  <= g0_vld_n;
      g0_tid_q  <= g0_tid_n;
      g0_slot_q <= g0_slot_n;
      g1_vld_q  <= g1_vld_n;
      g1_tid_q  <= g1_tid_n;
      g1_fill_q <= g1_fill_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)    ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  // leftover budget for the second thread follows the first thread's usage
  always_comb begin
    if (used0_i >= SW'(SLOTS)) left = '0;
    else                       left = SW'(SLOTS) - used0_i;
  end

  assign g0_vld_o   = g0_vld_q;
  assign g0_tid_o   = g0_tid_q;
  assign g0_slots_o = g0_slot_q;
  assign g1_vld_o   = g1_vld_q;
  assign g1_tid_o   = g1_tid_q;
  assign g1_slots_o = !g1_vld_q ? '0 : (g1_fill_q ? left : SW'(HALF));
endmodule

// File: rtl/fetch_thread_sel_chk.sv
module fetch_thread_sel_chk #(
  parameter int NTHR  = 8,
  parameter int TW    = 3,
  parameter int SW    = 4,
  parameter int SLOTS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      pol_i,
  input logic            dual_i,
  input logic [NTHR-1:0] elig_i,
  input logic [SW-1:0]   used0_i,
  input logic            g0_vld_o,
  input logic [TW-1:0]   g0_tid_o,
  input logic [SW-1:0]   g0_slots_o,
  input logic            g1_vld_o,
  input logic [TW-1:0]   g1_tid_o,
  input logic [SW-1:0]   g1_slots_o
);
  logic [NTHR-1:0] elig_q;
  logic [1:0]      pol_q;
  logic            dual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= '0;
      pol_q  <= '0;
      dual_q <= 1'b0;
    end else begin
      elig_q <= elig_i;
      pol_q  <= pol_i;
      dual_q <= dual_i;
    end
  end

  p_first_elig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g0_vld_o |-> elig_q[g0_tid_o]);

  p_second_elig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1_vld_o |-> elig_q[g1_tid_o]);

  p_none_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_q == '0) |-> (!g0_vld_o && !g1_vld_o));

  p_two_distinct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1_vld_o |-> (g0_vld_o && (g0_tid_o != g1_tid_o)));

  p_single_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_q |-> !g1_vld_o);

  p_rotate_budget_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g0_vld_o && pol_q == 2'd0 && !dual_q) |-> (g0_slots_o == SW'(SLOTS)));

  p_leftover_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1_vld_o && pol_q != 2'd0 && used0_i <= SW'(SLOTS))
      |-> ((SW+1)'(g1_slots_o) + (SW+1)'(used0_i) == (SW+1)'(SLOTS)));
endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(
  .NTHR(NTHR), .TW(TW), .SW(SW), .SLOTS(SLOTS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pol_i      (pol_i),
  .dual_i     (dual_i),
  .elig_i     (elig_i),
  .used0_i    (used0_i),
  .g0_vld_o   (g0_vld_o),
  .g0_tid_o   (g0_tid_o),
  .g0_slots_o (g0_slots_o),
  .g1_vld_o   (g1_vld_o),
  .g1_tid_o   (g1_tid_o),
  .g1_slots_o (g1_slots_o)
);

// File: tb/sim_fetch_thread_sel.sv
module sim_fetch_thread_sel;
  localparam int PERIOD = 10;
  localparam int N  = 8;
  localparam int CW = 6;
  localparam int SW = 4;
  localparam int TW = 3;

  logic            clk, rst_n, dual;
  logic [1:0]      pol;
  logic [N-1:0]    elig, br_new, br_done, miss_new, miss_done;
  logic [N*SW-1:0] fetched, issued;
  logic [N*CW-1:0] squashed;
  logic [SW-1:0]   used0;
  logic            g0_vld, g1_vld;
  logic [TW-1:0]   g0_tid, g1_tid;
  logic [SW-1:0]   g0_slots, g1_slots;

  int n_chk, n_fail;
  bit finished;

  fetch_thread_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .pol_i(pol), .dual_i(dual), .elig_i(elig),
    .fetched_i(fetched), .issued_i(issued), .squashed_i(squashed),
    .br_new_i(br_new), .br_done_i(br_done), .miss_new_i(miss_new),
    .miss_done_i(miss_done), .used0_i(used0),
    .g0_vld_o(g0_vld), .g0_tid_o(g0_tid), .g0_slots_o(g0_slots),
    .g1_vld_o(g1_vld), .g1_tid_o(g1_tid), .g1_slots_o(g1_slots)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    fetched = '0; issued = '0; squashed = '0;
    br_new = '0; br_done = '0; miss_new = '0; miss_done = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pol = 2'd0; dual = 1'b0; elig = '0; used0 = '0;
    clear_ev();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // apply the current event vectors for exactly one edge
  task automatic pulse();
    @(negedge clk);
    clear_ev();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 g0 valid", int'(g0_vld), 0);
    check("R1 g1 valid", int'(g1_vld), 0);
    check("R1 g1 slots", int'(g1_slots), 0);
    pol = 2'd1; elig = '1;
    @(negedge clk);
    check("R1 zero counters, pointer 0", int'(g0_tid), 0);
  endtask

  task automatic t_rr_single();
    do_reset();
    pol = 2'd0; dual = 1'b0; elig = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5 rotate tid", int'(g0_tid), i);
      check("R5 rotate slots", int'(g0_slots), 8);
    end
    elig = '0;
    #1 check("R12 grant held until edge", int'(g0_vld), 1);
    @(negedge clk);
    check("R12 grant drops one edge later", int'(g0_vld), 0);
  endtask

  task automatic t_rr_dual();
    do_reset();
    pol = 2'd0; dual = 1'b1; elig = '1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R6 first tid", int'(g0_tid), 2*i);
      check("R6 second tid", int'(g1_tid), 2*i + 1);
      check("R6 first slots", int'(g0_slots), 4);
      check("R6 second slots", int'(g1_slots), 4);
    end
  endtask

  task automatic t_rr_skip();
    int exp_t [4] = '{2, 5, 7, 2};
    do_reset();
    pol = 2'd0; elig = 8'b1010_0100;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 skip blocked threads", int'(g0_tid), exp_t[i]);
    end
    elig = '0; dual = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 nothing eligible g0", int'(g0_vld), 0);
    check("R9 nothing eligible g1", int'(g1_vld), 0);
  endtask

  task automatic t_lone();
    do_reset();
    pol = 2'd1; dual = 1'b1; elig = 8'b0001_0000;
    @(negedge clk);
    check("R10 lone tid", int'(g0_tid), 4);
    check("R10 lone slots", int'(g0_slots), 8);
    check("R10 no second", int'(g1_vld), 0);
    check("R10 second slots", int'(g1_slots), 0);
    pol = 2'd0;
    @(negedge clk);
    check("R10 lone rotate slots", int'(g0_slots), 4);
    check("R10 lone rotate no second", int'(g1_vld), 0);
  endtask

  task automatic t_icount();
    int cnt [8] = '{5, 3, 7, 2, 6, 4, 8, 1};
    do_reset();
    @(negedge clk);
    for (int t = 0; t < N; t++) fetched[t*SW +: SW] = SW'(cnt[t]);
    pulse();
    pol = 2'd1; dual = 1'b0; elig = '1;
    @(negedge clk);
    check("R7 fewest unissued", int'(g0_tid), 7);
    check("R7 single slots", int'(g0_slots), 8);
    dual = 1'b1; used0 = 4'd5;
    @(negedge clk);
    check("R7 first of two", int'(g0_tid), 7);
    check("R7 runner-up", int'(g1_tid), 3);
    check("R11 leftover 8-5", int'(g1_slots), 3);
    used0 = 4'd8;
    #1 check("R11 leftover none", int'(g1_slots), 0);
    used0 = 4'd12;
    #1 check("R11 leftover clamp", int'(g1_slots), 0);
    used0 = 4'd0;
    #1 check("R11 leftover full", int'(g1_slots), 8);
  endtask

  task automatic t_tie();
    do_reset();
    pol = 2'd1; dual = 1'b1; elig = '1;
    @(negedge clk);
    check("R8 tie pair a", int'(g0_tid), 0);
    check("R8 tie pair b", int'(g1_tid), 1);
    @(negedge clk);
    check("R8 tie pair c", int'(g0_tid), 2);
    check("R8 tie pair d", int'(g1_tid), 3);
    dual = 1'b0; elig = 8'b1000_0001;
    @(negedge clk);
    check("R8 pointer past last", int'(g0_tid), 7);
    @(negedge clk);
    check("R8 pointer wraps", int'(g0_tid), 0);
    @(negedge clk);
    check("R8 pointer again", int'(g0_tid), 7);
  endtask

  task automatic t_sat();
    do_reset();
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      clear_ev();
      fetched[0 +: SW] = 4'd8;
      fetched[SW +: SW] = (c < 7) ? 4'd8 : ((c == 7) ? 4'd6 : 4'd0);
    end
    pulse();
    pol = 2'd1; elig = 8'b0000_0011;
    @(negedge clk);
    check("R3 clamp at 63 (t0 63 > t1 62)", int'(g0_tid), 1);
  endtask

  task automatic t_floor();
    do_reset();
    @(negedge clk);
    fetched[1*SW +: SW] = 4'd1;
    fetched[2*SW +: SW] = 4'd3;
    pulse();
    squashed[2*CW +: CW] = 6'd40;
    pulse();
    pol = 2'd1; elig = 8'b0000_0110;
    @(negedge clk);
    check("R3 floor at zero", int'(g0_tid), 2);
  endtask

  task automatic t_incdec();
    do_reset();
    @(negedge clk);
    fetched[4*SW +: SW] = 4'd5;
    issued[4*SW +: SW]  = 4'd2;
    fetched[5*SW +: SW] = 4'd4;
    pulse();
    pol = 2'd1; elig = 8'b0011_0000;
    @(negedge clk);
    check("R2 fetch and issue together", int'(g0_tid), 4);
  endtask

  task automatic t_branch();
    do_reset();
    @(negedge clk);
    br_new = 8'b0000_0011;
    fetched[0 +: SW] = 4'd1;
    fetched[SW +: SW] = 4'd5;
    pulse();
    br_new = 8'b0000_0001;
    pulse();
    pol = 2'd1; elig = 8'b0000_0011;
    @(negedge clk);
    check("R7 unissued picks t0", int'(g0_tid), 0);
    pol = 2'd2;
    @(negedge clk);
    check("R7 branch picks t1", int'(g0_tid), 1);
    elig = '0;
    br_done = 8'b0000_0001;
    pulse();
    br_done = 8'b0000_0001;
    pulse();
    elig = 8'b0000_0011;
    @(negedge clk);
    check("R4 branch resolve lowers t0", int'(g0_tid), 0);
  endtask

  task automatic t_miss();
    do_reset();
    @(negedge clk);
    miss_new = 8'b0000_1100;
    pulse();
    miss_new = 8'b0000_0100;
    pulse();
    pol = 2'd3; elig = 8'b0000_1100;
    @(negedge clk);
    check("R7 miss picks t3", int'(g0_tid), 3);
    elig = '0;
    miss_done = 8'b0000_0100;
    pulse();
    miss_done = 8'b0000_0100;
    pulse();
    elig = 8'b0000_1100;
    @(negedge clk);
    check("R4 miss return lowers t2", int'(g0_tid), 2);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    t_reset();
    t_rr_single();
    t_rr_dual();
    t_rr_skip();
    t_lone();
    t_icount();
    t_tie();
    t_sat();
    t_floor();
    t_incdec();
    t_branch();
    t_miss();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule